// File: doc/BRIEF.md
# Fractional-N Feedback Modulus Divider

This block divides a fast oscillator clock by an integer that may change on every output period. Each division length is a base integer plus a small signed offset. In the synthesizer loop, that offset comes from a delta-sigma modulator. Averaged over many periods, the division ratio is the base plus the mean of the offsets. The feedback frequency is therefore a fractional multiple of the oscillator frequency divided down. The default widths cover integer ratios of about 44 to 46, which a 880–915 MHz output from a 20 MHz reference needs, with plenty of margin.

The divider is a down-counter clocked by the oscillator. When it reaches its terminal count it does three things:
- it emits a one-cycle divided pulse;
- in the same cycle it raises a strobe that asks the modulator for its next sample;
- it captures the base and the offset presented in that cycle as the length of the next period.

Values presented at any other time have no effect. A sum that falls below 2 is raised to 2.

Top module: `fracn_modulus_divider`

## Requirements
- R1: While `rst_n_i` is low, `div_pulse_o` and `sample_req_o` are 0. In the first clock cycle after the first rising edge that follows the release of reset, `div_pulse_o` is 1.
- R2: The effective modulus is M = `base_n_i` + `offset_i`, sampled at the rising edge that ends a cycle in which `div_pulse_o` is 1. The next pulse arrives exactly M clock cycles after that pulse.
- R3: `offset_i` is a two's-complement signed value of OFS_W bits (default -8..7). A negative value shortens the period, for example base 45 with offset -3 gives 42 cycles.
- R4: When `base_n_i` + `offset_i` is below 2, the period is 2 cycles.
- R5: Changes of `base_n_i` and `offset_i` during cycles in which `div_pulse_o` is 0 have no effect on the running period.
- R6: `div_pulse_o` is high for exactly one clock cycle per period.
- R7: `sample_req_o` is 1 exactly in the cycles in which `div_pulse_o` is 1.
- R8: Over a sequence of periods, the total number of cycles equals the sum of the effective moduli. No cycle is gained or lost at period boundaries.
- R9: With the maximum base and maximum offset (255 + 7 by default), the period is the full sum (262) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| base_n_i | input | BASE_W | Unsigned base modulus |
| offset_i | input | OFS_W | Signed modulator offset |
| div_pulse_o | output | 1 | One-cycle divided-clock pulse at terminal count |
| sample_req_o | output | 1 | Request for the next modulator sample, coincident with the pulse |

## Verification
The assertions assume three things:
- the offset is a proper two's-complement value of the declared width;
- the base and the offset are stable across the clock edge at which they are captured;
- reset is asserted from time zero.

The bench changes its inputs only at falling edges, so every capture edge sees settled values. Between boundaries it deliberately scrambles both inputs; these values are legal but must be ignored. Its table and random offsets stay within the signed range. Edge cases are reached through legal bases near zero and at the top of the range, never through out-of-width values.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
    // smallest legal division length
    localparam int MOD_MIN = 2;
endpackage

// File: rtl/fmd_modulus_calc.sv
module fmd_modulus_calc #(
    parameter int BASE_W = 8,
    parameter int OFS_W  = 4,
    parameter int CNT_W  = BASE_W + 1
) (
    input  logic [BASE_W-1:0] base_n_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic [CNT_W-1:0]  mod_eff_o
);
    import fmd_pkg::*;

    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum_w;
    logic             too_small_w;

    always_comb begin
        sum_w       = {{(SUM_W-BASE_W){1'b0}}, base_n_i}
                    + {{(SUM_W-OFS_W){offset_i[OFS_W-1]}}, offset_i};
        too_small_w = sum_w[SUM_W-1] || (sum_w[CNT_W-1:0] < CNT_W'(MOD_MIN));
        mod_eff_o   = too_small_w ? CNT_W'(MOD_MIN) : sum_w[CNT_W-1:0];
    end
endmodule

// File: rtl/fmd_count_core.sv
module fmd_count_core #(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [CNT_W-1:0] mod_eff_i,
    output logic             tc_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        tc_w;

    always_comb begin
        st_d = st_q;
        tc_w = st_q.run && (st_q.cnt == '0);
        if (!st_q.run) begin
            st_d.run = 1'b1;
        end else if (tc_w) begin
            st_d.cnt = mod_eff_i - CNT_W'(1);
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc_o  = tc_w;
    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/fracn_modulus_divider.sv
module fracn_modulus_divider #(
    parameter int BASE_W = 8,
    parameter int OFS_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [BASE_W-1:0] base_n_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic              div_pulse_o,
    output logic              sample_req_o
);
    localparam int CNT_W = BASE_W + 1;

    logic [CNT_W-1:0] mod_eff_w;
    logic [CNT_W-1:0] cnt_w;
    logic             tc_w;

    fmd_modulus_calc #(
        .BASE_W(BASE_W),
        .OFS_W (OFS_W),
        .CNT_W (CNT_W)
    ) u_calc (
        .base_n_i (base_n_i),
        .offset_i (offset_i),
        .mod_eff_o(mod_eff_w)
    );

    fmd_count_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .mod_eff_i(mod_eff_w),
        .tc_o     (tc_w),
        .cnt_o    (cnt_w)
    );

    assign div_pulse_o  = tc_w;
    assign sample_req_o = tc_w;
endmodule

// File: rtl/fmd_checker.sv
module fmd_checker #(
    parameter int CNT_W = 9
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic             div_pulse_i,
    input logic             sample_req_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] mod_eff_i
);
    AST_RELOAD_AT_TC: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        div_pulse_i |=> (cnt_i == $past(mod_eff_i) - CNT_W'(1))); // R2
    AST_NO_MIDCOUNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cnt_i != '0) |=> (cnt_i == $past(cnt_i) - CNT_W'(1))); // R5
    AST_MOD_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mod_eff_i >= CNT_W'(2))); // R4
    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        div_pulse_i |=> !div_pulse_i); // R6
    AST_REQ_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (sample_req_i == div_pulse_i)); // R7
endmodule

bind fracn_modulus_divider fmd_checker #(.CNT_W(CNT_W)) u_fmd_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .div_pulse_i (div_pulse_o),
    .sample_req_i(sample_req_o),
    .cnt_i       (cnt_w),
    .mod_eff_i   (mod_eff_w)
);

// File: tb/fracn_modulus_divider_tb_top.sv
module fracn_modulus_divider_tb_top;
    localparam int BASE_W = 8;
    localparam int OFS_W  = 4;
    localparam int NVEC   = 14;

    // each entry: base, signed offset, expected period
    typedef struct packed {
        logic [7:0]  base;
        logic [3:0]  ofs;
        logic [15:0] per;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'd45,  4'sd0,  16'd45},  '{8'd45,  4'sd1,  16'd46},
        '{8'd45, -4'sd1,  16'd44},  '{8'd45, -4'sd3,  16'd42},
        '{8'd44,  4'sd2,  16'd46},  '{8'd46, -4'sd2,  16'd44},
        '{8'd45, -4'sd8,  16'd37},  '{8'd45,  4'sd7,  16'd52},
        '{8'd3,  -4'sd1,  16'd2},   '{8'd3,  -4'sd4,  16'd2},
        '{8'd0,   4'sd0,  16'd2},   '{8'd2,  -4'sd8,  16'd2},
        '{8'd255, 4'sd7,  16'd262}, '{8'd5,   4'sd0,  16'd5}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [BASE_W-1:0] base_n = 8'd45;
    logic [OFS_W-1:0]  offset = '0;
    logic              div_pulse;
    logic              sample_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fracn_modulus_divider #(.BASE_W(BASE_W), .OFS_W(OFS_W)) dut_i (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .base_n_i    (base_n),
        .offset_i    (offset),
        .div_pulse_o (div_pulse),
        .sample_req_o(sample_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at the negedge of a pulse cycle: drive next values, measure period
    task automatic run_period(input logic [7:0] b, input logic [3:0] o, output int per);
        per = 0;
        base_n = b;
        offset = o;
        do begin
            @(negedge clk);
            per++;
            if (per == 1) begin
                check("R6 pulse width", int'(div_pulse), 0);
            end
            if (sample_req != div_pulse) check("R7 req with pulse", int'(sample_req), int'(div_pulse));
            if (!div_pulse) begin
                base_n = 8'($urandom);      // R5 scramble mid-count
                offset = 4'($urandom);
            end
        end while (!div_pulse && per < 2000);
    endtask

    function automatic int eff(input logic [7:0] b, input logic [3:0] o);
        int s;
        s = int'(b) + int'($signed(o));
        return (s < 2) ? 2 : s;
    endfunction

    initial begin
        int per;
        int total;
        int expsum;
        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            check("R1 pulse in reset", int'(div_pulse), 0);
            check("R1 req in reset", int'(sample_req), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first pulse after release", int'(div_pulse), 1);

        // table walk: R2 R3 R4 R5 R9
        for (int i = 0; i < NVEC; i++) begin
            run_period(VECS[i].base, VECS[i].ofs, per);
            check("R2/R3/R4/R9 period", per, int'(VECS[i].per));
        end

        // random sequence: R2 R8
        total = 0;
        expsum = 0;
        for (int k = 0; k < 40; k++) begin
            logic [7:0] b;
            logic [3:0] o;
            b = 8'(44 + ($urandom % 3));
            o = 4'($urandom);
            run_period(b, o, per);
            check("R2 random period", per, eff(b, o));
            total += per;
            expsum += eff(b, o);
        end
        check("R8 total cycles", total, expsum);

        // R1 reset in mid-count
        run_period(8'd45, 4'd0, per);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pulse during mid reset", int'(div_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pulse after mid reset", int'(div_pulse), 1);
        run_period(8'd4, -4'sd3, per);
        check("R4 clamp after reset", per, 2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule